// File: doc/BRIEF.md
# Data Access Fault Priority Checker

This block decides, for one data memory access at a time, which single fault the access raises. It takes the requester's privilege levels, class flags decoded from the access's address space identifier, the access size, the low address bits, an external virtual-range verdict, the translation lookup hit result and the matched page's attributes. It reports one trap code together with the fault type, context type and side-effect flag that a status register would capture, plus a strobe that asks for the tag access register to be written.

Accesses may target ordinary memory or one of two internal register windows (scratch and queue). Windows skip the alignment, range and lookup checks and apply their own offset and privilege rules instead. Every check sits on a fixed priority chain, and only the highest-priority fault is reported. The verdict is registered: it appears one cycle after a valid input strobe.

Top module: `dac_fault_prio`

## Requirements
- R1: An access with priv_i=0, hpriv_i=0 and asi_unpriv_i=0 raises trap 1 (privileged action), fault type 3 (illegal identifier), context 2 (nucleus), with status write, ahead of every other check.
- R2: Otherwise, asi_hpriv_i=1 without hpriv_i raises trap 2 (data access exception), fault type 3, context 2.
- R3: Otherwise, for a memory access (kind_i 0) whose address AND (2^size_i - 1) is nonzero (size_i 0..3 = 1,2,4,8 bytes) the trap is 3 (not aligned), fault type 0 (other), context copied from ctx_i.
- R4: Otherwise, va_ok_i=0 raises trap 2, fault type 5 (out of range), side-effect flag 1, no tag write.
- R5: Otherwise, tlb_hit_i=0 pulses tag_wr_o and raises trap 6 when real_i=1, else trap 5; no status write, fault type, context and side-effect read 0.
- R6: After a hit, a privileged page touched with priv_i=0 raises trap 2, fault type 1 (privilege violation).
- R7: Next, a store (write_i=1) to a non-writable page raises trap 4 (fast protection), fault type 0.
- R8: Next, a no-fault page accessed with asi_nofault_i=0 raises trap 2, fault type 4.
- R9: Next, a side-effect page accessed with asi_nofault_i=1 raises trap 2, fault type 2. Every page fault of R6 to R9 pulses tag_wr_o and copies pg_sidefx_i into sidefx_o.
- R10: Scratch window (kind_i 1): offset above 0x38, or 0x20..0x2F without hpriv_i, raises trap 2, fault type 3, context 0 (primary), side-effect 1; lookup and range inputs are ignored.
- R11: Queue window (kind_i 2): neither priv_i nor hpriv_i gives trap 1; else an offset outside 0x3C0..0x3F8, or not 16-byte aligned without hpriv_i, gives trap 2; both with fault type 3, context 0, side-effect 1.
- R12: Results appear one cycle after valid_i with out_vld_o=1; a clean access reports trap 0 with all status fields 0; without valid_i no strobe rises.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access present this cycle |
| kind_i | input | 2 | 0 memory, 1 scratch window, 2 queue window |
| priv_i | input | 1 | Requester privileged |
| hpriv_i | input | 1 | Requester hyperprivileged |
| asi_unpriv_i | input | 1 | Identifier usable unprivileged |
| asi_hpriv_i | input | 1 | Identifier needs hyperprivilege |
| asi_nofault_i | input | 1 | Identifier is a no-fault kind |
| real_i | input | 1 | Real (untranslated) lookup |
| write_i | input | 1 | Access is a store |
| size_i | input | 2 | log2 of access bytes |
| addr_i | input | ADDR_W | Address or window offset |
| va_ok_i | input | 1 | Virtual address in range |
| tlb_hit_i | input | 1 | Lookup hit |
| pg_priv_i | input | 1 | Page privileged |
| pg_write_i | input | 1 | Page writable |
| pg_nofault_i | input | 1 | Page no-fault only |
| pg_sidefx_i | input | 1 | Page has side effects |
| ctx_i | input | 2 | Context type of this access |
| out_vld_o | output | 1 | Verdict valid |
| trap_o | output | 3 | Trap code |
| ftype_o | output | 3 | Fault type for status |
| ctx_o | output | 2 | Context type for status |
| sidefx_o | output | 1 | Side-effect flag for status |
| stat_wr_o | output | 1 | Capture status fields |
| tag_wr_o | output | 1 | Write tag access |

## Verification
Several faults are routinely true in the same cycle, and the block must keep only the higher one: a misaligned address with a missing privilege, an out-of-range address on a lookup miss, or a page that is at once privileged, read-only, no-fault and side-effecting. The vector table sets up such stacked conditions deliberately and expects exactly the top-priority trap and fault type, then removes the winner in a neighbouring vector to expose the next one down. Window vectors also hold a lookup miss and a misaligned offset while expecting only the window rule to act.

// File: rtl/dac_fault_pkg.sv
package dac_fault_pkg;
  typedef enum logic [2:0] {
    TRAP_NONE = 3'd0, TRAP_PRIV_ACT = 3'd1, TRAP_DATA_EXC = 3'd2,
    TRAP_NOT_ALIGNED = 3'd3, TRAP_FAST_PROT = 3'd4, TRAP_MISS = 3'd5,
    TRAP_REAL_MISS = 3'd6
  } trap_e;

  typedef enum logic [2:0] {
    FT_OTHER = 3'd0, FT_PRIV = 3'd1, FT_SIDEFX = 3'd2, FT_ILLEGAL = 3'd3,
    FT_NOFAULT = 3'd4, FT_RANGE = 3'd5
  } ftype_e;

  typedef enum logic [1:0] {
    CX_PRIMARY = 2'd0, CX_SECONDARY = 2'd1, CX_NUCLEUS = 2'd2
  } ctx_e;

  typedef enum logic [1:0] {
    KIND_MEM = 2'd0, KIND_SCRATCH = 2'd1, KIND_QUEUE = 2'd2
  } kind_e;

  typedef struct packed {
    trap_e  trap;
    ftype_e ft;
    ctx_e   cx;
    logic   sfx;
    logic   stat_wr;
    logic   tag_wr;
  } res_t;

  localparam res_t RES_NONE = '{trap: TRAP_NONE, ft: FT_OTHER, cx: CX_PRIMARY,
                                sfx: 1'b0, stat_wr: 1'b0, tag_wr: 1'b0};
endpackage

// File: rtl/dac_chk_asi.sv
module dac_chk_asi
  import dac_fault_pkg::*;
(
  input  logic priv_i,
  input  logic hpriv_i,
  input  logic asi_unpriv_i,
  input  logic asi_hpriv_i,
  output logic hit_o,
  output res_t res_o
);
  always_comb begin
    res_o = RES_NONE;
    hit_o = 1'b0;
    if (!priv_i && !hpriv_i && !asi_unpriv_i) begin
      hit_o = 1'b1;
      res_o = '{trap: TRAP_PRIV_ACT, ft: FT_ILLEGAL, cx: CX_NUCLEUS,
                sfx: 1'b0, stat_wr: 1'b1, tag_wr: 1'b0};
    end else if (!hpriv_i && asi_hpriv_i) begin
      hit_o = 1'b1;
      res_o = '{trap: TRAP_DATA_EXC, ft: FT_ILLEGAL, cx: CX_NUCLEUS,
                sfx: 1'b0, stat_wr: 1'b1, tag_wr: 1'b0};
    end
  end
endmodule

// File: rtl/dac_chk_mem.sv
module dac_chk_mem
  import dac_fault_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              priv_i,
  input  logic              asi_nofault_i,
  input  logic              real_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              va_ok_i,
  input  logic              tlb_hit_i,
  input  logic              pg_priv_i,
  input  logic              pg_write_i,
  input  logic              pg_nofault_i,
  input  logic              pg_sidefx_i,
  input  logic [1:0]        ctx_i,
  output res_t              res_o
);
  logic [3:0] size_mask;
  logic       misal;
  ctx_e       cx_in;

  assign size_mask = 4'((5'd1 << size_i) - 5'd1);
  assign misal     = |(addr_i[3:0] & size_mask);
  assign cx_in     = ctx_e'(ctx_i);

  function automatic res_t pg_fault(trap_e t, ftype_e f, ctx_e c, logic s);
    return '{trap: t, ft: f, cx: c, sfx: s, stat_wr: 1'b1, tag_wr: 1'b1};
  endfunction

  always_comb begin
    res_o = RES_NONE;
    if (misal)
      res_o = '{trap: TRAP_NOT_ALIGNED, ft: FT_OTHER, cx: cx_in,
                sfx: 1'b0, stat_wr: 1'b1, tag_wr: 1'b0};
    else if (!va_ok_i)
      res_o = '{trap: TRAP_DATA_EXC, ft: FT_RANGE, cx: cx_in,
                sfx: 1'b1, stat_wr: 1'b1, tag_wr: 1'b0};
    else if (!tlb_hit_i) begin
      res_o        = RES_NONE;
      res_o.trap   = real_i ? TRAP_REAL_MISS : TRAP_MISS;
      res_o.tag_wr = 1'b1;
    end
    else if (pg_priv_i && !priv_i)
      res_o = pg_fault(TRAP_DATA_EXC, FT_PRIV, cx_in, pg_sidefx_i);
    else if (write_i && !pg_write_i)
      res_o = pg_fault(TRAP_FAST_PROT, FT_OTHER, cx_in, pg_sidefx_i);
    else if (pg_nofault_i && !asi_nofault_i)
      res_o = pg_fault(TRAP_DATA_EXC, FT_NOFAULT, cx_in, pg_sidefx_i);
    else if (pg_sidefx_i && asi_nofault_i)
      res_o = pg_fault(TRAP_DATA_EXC, FT_SIDEFX, cx_in, pg_sidefx_i);
  end
endmodule

// File: rtl/dac_chk_win.sv
module dac_chk_win
  import dac_fault_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SCR_MAX = 'h38,
  parameter int SCR_HLO = 'h20,
  parameter int SCR_HHI = 'h30,
  parameter int Q_LO    = 'h3C0,
  parameter int Q_HI    = 'h3F8
) (
  input  logic              is_queue_i,
  input  logic              priv_i,
  input  logic              hpriv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output res_t              res_o
);
  localparam logic [ADDR_W-1:0] ScrMax = ADDR_W'(SCR_MAX);
  localparam logic [ADDR_W-1:0] ScrHlo = ADDR_W'(SCR_HLO);
  localparam logic [ADDR_W-1:0] ScrHhi = ADDR_W'(SCR_HHI);
  localparam logic [ADDR_W-1:0] QLo    = ADDR_W'(Q_LO);
  localparam logic [ADDR_W-1:0] QHi    = ADDR_W'(Q_HI);

  logic scr_bad, q_bad;
  assign scr_bad = (addr_i > ScrMax) ||
                   (addr_i >= ScrHlo && addr_i < ScrHhi && !hpriv_i);
  assign q_bad   = (!hpriv_i && |addr_i[3:0]) || addr_i > QHi || addr_i < QLo;

  always_comb begin
    res_o = '{trap: TRAP_DATA_EXC, ft: FT_ILLEGAL, cx: CX_PRIMARY,
              sfx: 1'b1, stat_wr: 1'b1, tag_wr: 1'b0};
    if (is_queue_i) begin
      if (!priv_i && !hpriv_i) res_o.trap = TRAP_PRIV_ACT;
      else if (!q_bad)         res_o = RES_NONE;
    end else if (!scr_bad) begin
      res_o = RES_NONE;
    end
  end
endmodule

// File: rtl/dac_fault_prio.sv
module dac_fault_prio
  import dac_fault_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic              priv_i,
  input  logic              hpriv_i,
  input  logic              asi_unpriv_i,
  input  logic              asi_hpriv_i,
  input  logic              asi_nofault_i,
  input  logic              real_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              va_ok_i,
  input  logic              tlb_hit_i,
  input  logic              pg_priv_i,
  input  logic              pg_write_i,
  input  logic              pg_nofault_i,
  input  logic              pg_sidefx_i,
  input  logic [1:0]        ctx_i,
  output logic              out_vld_o,
  output logic [2:0]        trap_o,
  output logic [2:0]        ftype_o,
  output logic [1:0]        ctx_o,
  output logic              sidefx_o,
  output logic              stat_wr_o,
  output logic              tag_wr_o
);
  logic asi_hit;
  res_t asi_res, mem_res, win_res, nxt, res_q;
  logic vld_q;
  logic is_win;

  assign is_win = (kind_i == KIND_SCRATCH) || (kind_i == KIND_QUEUE);

  dac_chk_asi u_asi (
    .priv_i(priv_i), .hpriv_i(hpriv_i), .asi_unpriv_i(asi_unpriv_i),
    .asi_hpriv_i(asi_hpriv_i), .hit_o(asi_hit), .res_o(asi_res));

  dac_chk_mem #(.ADDR_W(ADDR_W)) u_mem (
    .priv_i(priv_i), .asi_nofault_i(asi_nofault_i), .real_i(real_i),
    .write_i(write_i), .size_i(size_i), .addr_i(addr_i), .va_ok_i(va_ok_i),
    .tlb_hit_i(tlb_hit_i), .pg_priv_i(pg_priv_i), .pg_write_i(pg_write_i),
    .pg_nofault_i(pg_nofault_i), .pg_sidefx_i(pg_sidefx_i), .ctx_i(ctx_i),
    .res_o(mem_res));

  dac_chk_win #(.ADDR_W(ADDR_W)) u_win (
    .is_queue_i(kind_i == KIND_QUEUE), .priv_i(priv_i), .hpriv_i(hpriv_i),
    .addr_i(addr_i), .res_o(win_res));

  always_comb begin
    if (asi_hit)     nxt = asi_res;
    else if (is_win) nxt = win_res;
    else             nxt = mem_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= RES_NONE;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= nxt;
    end
  end

  assign out_vld_o = vld_q;
  assign trap_o    = res_q.trap;
  assign ftype_o   = res_q.ft;
  assign ctx_o     = res_q.cx;
  assign sidefx_o  = res_q.sfx;
  assign stat_wr_o = vld_q & res_q.stat_wr;
  assign tag_wr_o  = vld_q & res_q.tag_wr;

  p_nucleus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !priv_i && !hpriv_i && !asi_unpriv_i |=>
      trap_o == TRAP_PRIV_ACT && ctx_o == CX_NUCLEUS && ftype_o == FT_ILLEGAL);

  p_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == KIND_MEM && (priv_i || hpriv_i) && !asi_hpriv_i &&
    addr_i[0] && size_i != 2'd0 |=> trap_o == TRAP_NOT_ALIGNED);

  p_range_sfx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && ftype_o == FT_RANGE |-> sidefx_o);

  p_miss_tag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && (trap_o == TRAP_MISS || trap_o == TRAP_REAL_MISS) |->
      tag_wr_o && !stat_wr_o);

  p_scr_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == KIND_SCRATCH && (priv_i || hpriv_i) && !asi_hpriv_i &&
    addr_i > ADDR_W'('h38) |=> trap_o == TRAP_DATA_EXC && ctx_o == CX_PRIMARY);

  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> !tag_wr_o && !stat_wr_o);

  p_none_clean_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && trap_o == TRAP_NONE |-> !tag_wr_o && !stat_wr_o);
endmodule

// File: tb/sim_dac_fault_prio.sv
module sim_dac_fault_prio;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5ns clk_i = ~clk_i;

  logic        valid_i;
  logic [1:0]  kind_i, size_i, ctx_i;
  logic        priv_i, hpriv_i, asi_unpriv_i, asi_hpriv_i, asi_nofault_i;
  logic        real_i, write_i, va_ok_i, tlb_hit_i;
  logic        pg_priv_i, pg_write_i, pg_nofault_i, pg_sidefx_i;
  logic [15:0] addr_i;
  logic        out_vld_o, sidefx_o, stat_wr_o, tag_wr_o;
  logic [2:0]  trap_o, ftype_o;
  logic [1:0]  ctx_o;

  dac_fault_prio #(.ADDR_W(16)) u0 (.*);

  typedef struct packed {
    logic [1:0] kind; logic pv, hp, au, ah, an, rl, wr; logic [1:0] sz;
    logic [15:0] ad; logic vo, hit, pp, pw, pnf, psx; logic [1:0] cx;
    logic [2:0] e_trap, e_ft; logic [1:0] e_cx; logic e_sx, e_tw, e_sw;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{0,1,0,0,0,0,0,0,3,'h10, 1,1,0,1,0,0,1, 0,0,0,0,0,0, 12}, // R12 clean
    '{0,0,0,0,0,0,0,0,3,'h11, 1,1,0,1,0,0,1, 1,3,2,0,0,1,  1}, // R1 over misalign
    '{0,0,0,1,0,0,0,0,3,'h10, 1,1,0,1,0,0,1, 0,0,0,0,0,0,  1}, // R1 unpriv id ok
    '{0,1,0,0,1,0,0,0,3,'h11, 1,1,0,1,0,0,1, 2,3,2,0,0,1,  2}, // R2
    '{0,0,1,0,1,0,0,0,3,'h10, 1,1,0,1,0,0,1, 0,0,0,0,0,0,  2}, // R2 with hpriv
    '{0,1,0,0,0,0,0,0,2,'h12, 0,0,0,1,0,0,1, 3,0,1,0,0,1,  3}, // R3 over range
    '{0,1,0,0,0,0,0,0,1,'h12, 1,1,0,1,0,0,1, 0,0,0,0,0,0,  3}, // R3 2-byte ok
    '{0,1,0,0,0,0,0,0,0,'h13, 1,1,0,1,0,0,0, 0,0,0,0,0,0,  3}, // R3 byte ok
    '{0,1,0,0,0,0,0,0,3,'h10, 0,0,0,1,0,0,1, 2,5,1,1,0,1,  4}, // R4 over miss
    '{0,1,0,0,0,0,0,0,3,'h10, 1,0,1,0,1,1,1, 5,0,0,0,1,0,  5}, // R5 miss
    '{0,1,0,0,0,0,1,0,3,'h10, 1,0,0,1,0,0,1, 6,0,0,0,1,0,  5}, // R5 real miss
    '{0,0,0,1,0,0,0,1,3,'h10, 1,1,1,0,1,1,1, 2,1,1,1,1,1,  6}, // R6 stacked
    '{0,1,0,0,0,0,0,1,3,'h10, 1,1,1,0,1,1,0, 4,0,0,1,1,1,  7}, // R7 stacked
    '{0,1,0,0,0,0,0,0,3,'h10, 1,1,0,1,1,1,1, 2,4,1,1,1,1,  8}, // R8
    '{0,1,0,0,0,1,0,0,3,'h10, 1,1,0,1,1,1,1, 2,2,1,1,1,1,  9}, // R9
    '{0,1,0,0,0,1,0,0,3,'h10, 1,1,0,1,1,0,1, 0,0,0,0,0,0,  9}, // R9 no sfx
    '{1,1,0,0,0,0,0,0,3,'h38, 0,0,0,1,0,0,1, 0,0,0,0,0,0, 10}, // R10 top ok
    '{1,1,0,0,0,0,0,0,3,'h40, 1,1,0,1,0,0,1, 2,3,0,1,0,1, 10}, // R10 high
    '{1,1,0,0,0,0,0,0,3,'h28, 1,1,0,1,0,0,1, 2,3,0,1,0,1, 10}, // R10 hyp range
    '{1,0,1,0,0,0,0,0,3,'h28, 1,1,0,1,0,0,1, 0,0,0,0,0,0, 10}, // R10 hpriv ok
    '{1,1,0,0,0,0,0,0,3,'h30, 1,1,0,1,0,0,1, 0,0,0,0,0,0, 10}, // R10 0x30 ok
    '{2,0,0,1,0,0,0,0,3,'h3C0,1,1,0,1,0,0,1, 1,3,0,1,0,1, 11}, // R11 user
    '{2,1,0,0,0,0,0,0,3,'h3C8,1,1,0,1,0,0,1, 2,3,0,1,0,1, 11}, // R11 unaligned
    '{2,0,1,0,0,0,0,0,3,'h3C8,1,1,0,1,0,0,1, 0,0,0,0,0,0, 11}, // R11 hpriv ok
    '{2,1,0,0,0,0,0,0,3,'h3F0,0,0,0,1,0,0,1, 0,0,0,0,0,0, 11}, // R11 ok
    '{2,0,1,0,0,0,0,0,3,'h400,1,1,0,1,0,0,1, 2,3,0,1,0,1, 11}, // R11 above
    '{2,0,1,0,0,0,0,0,3,'h3B8,1,1,0,1,0,0,1, 2,3,0,1,0,1, 11}  // R11 below
  };

  int total = 0, bad = 0;
  bit done = 0;

  task automatic apply(input vec_t v, input logic vld);
    valid_i = vld; kind_i = v.kind; priv_i = v.pv; hpriv_i = v.hp;
    asi_unpriv_i = v.au; asi_hpriv_i = v.ah; asi_nofault_i = v.an;
    real_i = v.rl; write_i = v.wr; size_i = v.sz; addr_i = v.ad;
    va_ok_i = v.vo; tlb_hit_i = v.hit; pg_priv_i = v.pp; pg_write_i = v.pw;
    pg_nofault_i = v.pnf; pg_sidefx_i = v.psx; ctx_i = v.cx;
  endtask

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] outs();
    return {out_vld_o, trap_o, ftype_o, ctx_o, sidefx_o, tag_wr_o, stat_wr_o, 1'b0};
  endfunction

  initial begin
    apply(VECS[0], 1'b0);
    #22ns;
    check("R13 reset", outs(), 14'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R13 idle after reset", outs(), 14'd0);
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], 1'b1);
      @(negedge clk_i);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), outs(),
            {1'b1, VECS[i].e_trap, VECS[i].e_ft, VECS[i].e_cx,
             VECS[i].e_sx, VECS[i].e_tw, VECS[i].e_sw, 1'b0});
    end
    // R12: miss offered without valid raises no strobe
    apply(VECS[9], 1'b0);
    @(negedge clk_i);
    check("R12 no valid", {out_vld_o, tag_wr_o, stat_wr_o}, 3'b000);
    // R12: one-cycle latency, verdict absent before the edge
    @(negedge clk_i);
    apply(VECS[10], 1'b1);
    #2ns;
    check("R12 latency before", {11'd0, out_vld_o, tag_wr_o, stat_wr_o}, 14'd0);
    @(negedge clk_i);
    apply(VECS[10], 1'b0);
    check("R5 R12 latency after", {11'd0, out_vld_o, tag_wr_o, trap_o == 3'd6}, 14'd7);
    @(negedge clk_i);
    check("R12 strobe single cycle", {11'd0, out_vld_o, tag_wr_o, stat_wr_o}, 14'd0);
    // R13: reset mid-run clears verdict
    rst_ni = 1'b0;
    #2ns;
    check("R13 async reset", outs(), 14'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000ns;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R12 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule